// File: doc/BRIEF.md
# Signed Radix-4 Multiply-Accumulate Unit

This block multiplies two 32-bit two's-complement operands and adds the product into a wider running sum, one product per clock. The multiplier operand is recoded two bits at a time into signed digits. Each digit picks zero, the multiplicand, or twice the multiplicand, possibly negated, so 16 partial product rows are formed instead of 32. The rows are not sign-extended to full width. Each row keeps a single inverted sign bit, and one precomputed constant word supplies the missing high-order ones. A negated row gets its +1 as a separate dot in the same column matrix, so no separate adder is needed for it.

The dot matrix is compressed column by column with full and half adders. The stage heights follow the shortest schedule that ends at two rows (13, 9, 6, 4, 3, 2). A column is compressed only as far as the next stage height requires. One carry-propagate adder turns the last two rows into the 64-bit product. The product is sign-extended by a configurable number of guard bits and added into a single accumulator register.

The accumulator changes only on a rising edge where either the strobe or the clear is high. A clear starts a new sum. A clear with the strobe high loads the current product, and a clear with the strobe low loads zero.

Top module: `sr4_mac`

## Requirements
- R1: While the reset input is low the accumulator output is zero. Asserting reset clears the output at once, without waiting for a clock edge. After release the output stays zero until the first operation.
- R2: On a rising edge with valid high and clear low, the accumulator becomes its previous value plus the exact signed product of the two operands. Both operands are two's complement, and the product is sign-extended to the accumulator width. The new value appears at the output after that same edge.
- R3: On a rising edge with valid and clear both low, the accumulator keeps its value, whatever the operand inputs carry.
- R4: On a rising edge with clear and valid both high, the accumulator is loaded with the sign-extended product of the current operands. The previous sum is discarded.
- R5: On a rising edge with clear high and valid low, the accumulator becomes zero.
- R6: The product of the most negative operand with itself (0x80000000 × 0x80000000) is +2^62 and is added as a positive value.
- R7: The product 0x80000000 × 0x7FFFFFFF equals −2^62 + 2^31, which is 0xC000000080000000 as a 64-bit value.
- R8: An accumulate step in which either operand is zero leaves the accumulator unchanged.
- R9: The accumulator has 2×32 + GUARD bits (72 by default) and wraps modulo 2^72. 512 additions of 2^62 give 0x80_0000_0000_0000_0000, and 1024 additions give zero.
- R10: Adding x×y and then (−x)×y returns the accumulator to its starting value, for any x whose negation is representable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through an internal two-flop synchronizer |
| valid_i | input | 1 | Operand strobe; when high the current product enters the accumulator |
| clear_i | input | 1 | Synchronous start-of-sum; loads the product (valid high) or zero (valid low) |
| a_i | input | N (32) | Multiplicand, two's complement |
| b_i | input | N (32) | Multiplier, two's complement; recoded into radix-4 digits |
| acc_o | output | 2N+GUARD (72) | Registered accumulator value, two's complement |

## Verification
The bench builds the unit with its defaults, N = 32 and GUARD = 8. With these values every recoded digit pattern and the extreme operand pairs sit at the real 64-bit product width. The 8 guard bits also put the wrap point of the 72-bit sum within about a thousand accumulations of 2^62, so the modulo behaviour is observed directly rather than inferred. A table of operand pairs with hand-derived products and ten thousand random pairs, compared against a 72-bit behavioural sum, exercise the constant-ones sign handling across all rows.

// File: rtl/sr4_mac_pkg.sv
package sr4_mac_pkg;

  // One recoded radix-4 digit: magnitude select plus sign.
  typedef struct packed {
    logic neg;   // digit is negative
    logic one;   // magnitude 1
    logic two;   // magnitude 2
  } sr4_digit_t;

  // Next allowed height in the minimal reduction schedule.
  function automatic int sched_next(input int d);
    return (d * 3) / 2;
  endfunction

  // Number of compression stages needed to bring height h down to 2.
  function automatic int sched_stages(input int h);
    int d;
    int n;
    d = 2;
    n = 0;
    while (d < h) begin
      n = n + 1;
      d = sched_next(d);
    end
    return n;
  endfunction

  // k-th height of the schedule counted upward from 2 (k = 0 -> 2).
  function automatic int sched_height(input int k);
    int d;
    d = 2;
    for (int i = 0; i < k; i++) d = sched_next(d);
    return d;
  endfunction

endpackage

// File: rtl/sr4_rst_sync.sv
module sr4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/sr4_booth_row.sv
module sr4_booth_row
  import sr4_mac_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] mcand_i,
  input  logic [2:0]   grp_i,    // {b[2i+1], b[2i], b[2i-1]}
  output logic [N:0]   row_o,    // selected multiple, sign bit inverted
  output logic         neg_o     // +1 owed at the row LSB
);

  sr4_digit_t dig;
  logic [N:0] mult;
  logic [N:0] flip;

  // Digit recoding: value = -2*g2 + g1 + g0.
  always_comb begin
    dig.neg = grp_i[2] & ~(grp_i[1] & grp_i[0]);
    dig.one = grp_i[1] ^ grp_i[0];
    dig.two = (grp_i[2] & ~grp_i[1] & ~grp_i[0]) |
              (~grp_i[2] & grp_i[1] & grp_i[0]);
  end

  // Multiple selection and conditional one's complement.
  always_comb begin
    mult = '0;
    if (dig.one)      mult = {mcand_i[N-1], mcand_i};
    else if (dig.two) mult = {mcand_i, 1'b0};
    flip  = mult ^ {(N+1){dig.neg}};
    row_o = {~flip[N], flip[N-1:0]};
    neg_o = dig.neg;
  end

endmodule

// File: rtl/sr4_ctree.sv
module sr4_ctree
  import sr4_mac_pkg::*;
#(
  parameter int N    = 32,
  parameter int NDIG = N / 2
) (
  input  logic [NDIG-1:0][N:0] row_i,
  input  logic [NDIG-1:0]      neg_i,
  output logic [2*N-1:0]       sum_a_o,
  output logic [2*N-1:0]       sum_b_o
);

  localparam int W    = 2 * N;
  localparam int MAXH = NDIG + 2;
  localparam int NST  = sched_stages(MAXH);

  // Constant word replacing the sign extension of every row:
  // minus the sum of 2^(N+2i) over all rows, modulo 2^W.
  function automatic logic [W-1:0] ones_word();
    logic [W-1:0] k;
    k = '0;
    for (int i = 0; i < NDIG; i++) k = k - (W'(1) << (N + 2 * i));
    return k;
  endfunction

  localparam logic [W-1:0] KBITS = ones_word();

  always_comb begin : reduce
    logic [MAXH-1:0] cur [W];
    logic [MAXH-1:0] nxt [W];
    int              cnt [W];
    int              ncnt [W];
    logic [2:0]      win;
    int              h;
    int              p;
    int              tgt;
    int              cx;
    logic            s;
    logic            co;

    win = '0;
    h   = 0;
    p   = 0;
    tgt = 0;
    cx  = 0;
    s   = 1'b0;
    co  = 1'b0;
    for (int c = 0; c < W; c++) begin
      cur[c]  = '0;
      nxt[c]  = '0;
      cnt[c]  = 0;
      ncnt[c] = 0;
    end

    // Load the dot matrix: rows, negation ones, constant ones.
    for (int r = 0; r < NDIG; r++) begin
      for (int k = 0; k <= N; k++) begin
        if (2 * r + k < W) begin
          cur[2*r+k] = cur[2*r+k] | (MAXH'(row_i[r][k]) << cnt[2*r+k]);
          cnt[2*r+k] = cnt[2*r+k] + 1;
        end
      end
      cur[2*r] = cur[2*r] | (MAXH'(neg_i[r]) << cnt[2*r]);
      cnt[2*r] = cnt[2*r] + 1;
    end
    for (int c = 0; c < W; c++) begin
      if (KBITS[c]) begin
        cur[c] = cur[c] | (MAXH'(1'b1) << cnt[c]);
        cnt[c] = cnt[c] + 1;
      end
    end

    // Stages, tallest target first; each column compressed just enough.
    for (int st = 0; st < NST; st++) begin
      tgt = sched_height(NST - 1 - st);
      for (int c = 0; c < W; c++) begin
        nxt[c]  = '0;
        ncnt[c] = 0;
      end
      for (int c = 0; c < W; c++) begin
        cx = (c + 1 < W) ? c + 1 : W - 1;
        h  = cnt[c] + ncnt[c];
        p  = 0;
        for (int g = 0; g < MAXH; g++) begin
          win = 3'(cur[c] >> p);
          if (h > tgt && h - tgt >= 2 && cnt[c] - p >= 3) begin
            s  = win[0] ^ win[1] ^ win[2];
            co = (win[0] & win[1]) | (win[0] & win[2]) | (win[1] & win[2]);
            nxt[c]  = nxt[c] | (MAXH'(s) << ncnt[c]);
            ncnt[c] = ncnt[c] + 1;
            if (c + 1 < W) begin
              nxt[cx]  = nxt[cx] | (MAXH'(co) << ncnt[cx]);
              ncnt[cx] = ncnt[cx] + 1;
            end
            p = p + 3;
            h = h - 2;
          end else if (h > tgt && cnt[c] - p >= 2) begin
            s  = win[0] ^ win[1];
            co = win[0] & win[1];
            nxt[c]  = nxt[c] | (MAXH'(s) << ncnt[c]);
            ncnt[c] = ncnt[c] + 1;
            if (c + 1 < W) begin
              nxt[cx]  = nxt[cx] | (MAXH'(co) << ncnt[cx]);
              ncnt[cx] = ncnt[cx] + 1;
            end
            p = p + 2;
            h = h - 1;
          end
        end
        // Untouched dots pass straight to the next stage.
        for (int q = 0; q < MAXH; q++) begin
          if (q >= p && q < cnt[c]) begin
            s       = 1'(cur[c] >> q);
            nxt[c]  = nxt[c] | (MAXH'(s) << ncnt[c]);
            ncnt[c] = ncnt[c] + 1;
          end
        end
      end
      for (int c = 0; c < W; c++) begin
        cur[c] = nxt[c];
        cnt[c] = ncnt[c];
      end
    end

    for (int c = 0; c < W; c++) begin
      sum_a_o[c] = cur[c][0];
      sum_b_o[c] = cur[c][1];
    end
  end

endmodule

// File: rtl/sr4_acc_reg.sv
module sr4_acc_reg #(
  parameter int ACC_W = 72
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             clear_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  always_comb begin
    acc_en = valid_i | clear_i;
    acc_d  = acc_q;
    if (clear_i)      acc_d = valid_i ? addend_i : '0;
    else if (valid_i) acc_d = acc_q + addend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> $stable(acc_q)); // R3

  AST_CLEAR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && valid_i) |=> (acc_q == $past(addend_i))); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !valid_i) |=> (acc_q == '0)); // R5

endmodule

// File: rtl/sr4_mac.sv
module sr4_mac
  import sr4_mac_pkg::*;
#(
  parameter int N     = 32,
  parameter int GUARD = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 clear_i,
  input  logic [N-1:0]         a_i,
  input  logic [N-1:0]         b_i,
  output logic [2*N+GUARD-1:0] acc_o
);

  localparam int W     = 2 * N;
  localparam int NDIG  = N / 2;
  localparam int ACC_W = W + GUARD;

  logic                  rst_sync_n;
  logic [N:0]            b_pad;
  logic [NDIG-1:0][N:0]  rows;
  logic [NDIG-1:0]       negs;
  logic [W-1:0]          sum_a;
  logic [W-1:0]          sum_b;
  logic [W-1:0]          prod;
  logic [ACC_W-1:0]      prod_ext;

  sr4_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  // Implicit zero below the multiplier LSB.
  assign b_pad = {b_i, 1'b0};

  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_row
      sr4_booth_row #(.N(N)) u_row (
        .mcand_i (a_i),
        .grp_i   (b_pad[2*i+2:2*i]),
        .row_o   (rows[i]),
        .neg_o   (negs[i])
      );
    end
  endgenerate

  sr4_ctree #(.N(N), .NDIG(NDIG)) u_ctree (
    .row_i   (rows),
    .neg_i   (negs),
    .sum_a_o (sum_a),
    .sum_b_o (sum_b)
  );

  // Final carry-propagate add and sign extension into the guard bits.
  always_comb begin
    prod     = sum_a + sum_b;
    prod_ext = {{GUARD{prod[W-1]}}, prod};
  end

  sr4_acc_reg #(.ACC_W(ACC_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .valid_i  (valid_i),
    .clear_i  (clear_i),
    .addend_i (prod_ext),
    .acc_o    (acc_o)
  );

  // Behavioural reference used only by the checks below.
  logic signed [W-1:0] a_sx;
  logic signed [W-1:0] b_sx;
  logic signed [W-1:0] ref_prod;
  assign a_sx     = {{N{a_i[N-1]}}, a_i};
  assign b_sx     = {{N{b_i[N-1]}}, b_i};
  assign ref_prod = a_sx * b_sx;

  AST_PRODUCT_EXACT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    valid_i |-> (prod == ref_prod)); // R2

  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (valid_i && !clear_i && (a_i == '0 || b_i == '0)) |=> $stable(acc_o)); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_o == '0)); // R1

endmodule

// File: tb/sr4_mac_tb.sv
`timescale 1ns/1ps
module sr4_mac_tb;

  localparam int N     = 32;
  localparam int GUARD = 8;
  localparam int ACC_W = 2 * N + GUARD;
  localparam int NV    = 12;

  // {a, b, expected 64-bit product}
  localparam logic [127:0] VEC [NV] = '{
    {32'h80000000, 32'h80000000, 64'h4000000000000000},
    {32'h80000000, 32'h7FFFFFFF, 64'hC000000080000000},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 64'h0000000000000001},
    {32'h7FFFFFFF, 32'h7FFFFFFF, 64'h3FFFFFFF00000001},
    {32'h00000000, 32'h12345678, 64'h0000000000000000},
    {32'h00000003, 32'hFFFFFFFB, 64'hFFFFFFFFFFFFFFF1},
    {32'h00010000, 32'h00010000, 64'h0000000100000000},
    {32'hFFFFFFFF, 32'h80000000, 64'h0000000080000000},
    {32'h55555555, 32'h00000002, 64'h00000000AAAAAAAA},
    {32'hAAAAAAAA, 32'h00000002, 64'hFFFFFFFF55555554},
    {32'h12345678, 32'h00000001, 64'h0000000012345678},
    {32'hFFFFFFFE, 32'h7FFFFFFF, 64'hFFFFFFFF00000002}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             vld;
  logic             clr;
  logic [N-1:0]     a;
  logic [N-1:0]     b;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] model;
  int               n_chk = 0;
  int               n_bad = 0;

  always #10 clk = ~clk;

  sr4_mac #(.N(N), .GUARD(GUARD)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (vld),
    .clear_i (clr),
    .a_i     (a),
    .b_i     (b),
    .acc_o   (acc)
  );

  function automatic logic [ACC_W-1:0] sext_prod(input logic [N-1:0] x, input logic [N-1:0] y);
    logic signed [2*N-1:0] xs;
    logic signed [2*N-1:0] ys;
    logic signed [2*N-1:0] p;
    xs = {{N{x[N-1]}}, x};
    ys = {{N{y[N-1]}}, y};
    p  = xs * ys;
    return {{GUARD{p[2*N-1]}}, p};
  endfunction

  task automatic chk(input string tag, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(input logic c, input logic v, input logic [N-1:0] x, input logic [N-1:0] y);
    clr = c;
    vld = v;
    a   = x;
    b   = y;
    @(posedge clk);
    @(negedge clk);
    if (c)      model = v ? sext_prod(x, y) : '0;
    else if (v) model = model + sext_prod(x, y);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk = n_chk + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    vld   = 1'b0;
    clr   = 1'b0;
    a     = '0;
    b     = '0;
    model = '0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", acc, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", acc, '0);

    // Table walk: load each product with clear+valid (R4).
    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, 1'b1, VEC[i][127:96], VEC[i][95:64]);
      chk("R4 table load", acc, {{GUARD{VEC[i][63]}}, VEC[i][63:0]});
    end

    // Clear with valid low (R5), then accumulate the table (R2).
    cyc(1'b1, 1'b0, 32'h0BADF00D, 32'h12345678);
    chk("R5 clear empty", acc, '0);
    for (int i = 0; i < NV; i++) begin
      cyc(1'b0, 1'b1, VEC[i][127:96], VEC[i][95:64]);
      chk("R2 table accumulate", acc, model);
    end

    // Idle cycles keep the sum (R3).
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b0, $urandom, $urandom);
      chk("R3 idle hold", acc, model);
    end

    // Zero operands change nothing (R8).
    cyc(1'b0, 1'b1, 32'h00000000, $urandom);
    chk("R8 zero multiplicand", acc, model);
    cyc(1'b0, 1'b1, $urandom, 32'h00000000);
    chk("R8 zero multiplier", acc, model);
    cyc(1'b0, 1'b1, 32'h80000000, 32'h00000000);
    chk("R8 zero times min", acc, model);

    // Extreme operand pairs (R6, R7).
    cyc(1'b1, 1'b1, 32'h80000000, 32'h80000000);
    chk("R6 min squared", acc, 72'h00_4000000000000000);
    cyc(1'b1, 1'b1, 32'h80000000, 32'h7FFFFFFF);
    chk("R7 min times max", acc, 72'hFF_C000000080000000);

    // Modulo wrap of the accumulator (R9).
    cyc(1'b1, 1'b1, 32'h80000000, 32'h80000000);
    for (int i = 0; i < 511; i++) cyc(1'b0, 1'b1, 32'h80000000, 32'h80000000);
    chk("R9 half wrap", acc, 72'h80_0000000000000000);
    for (int i = 0; i < 512; i++) cyc(1'b0, 1'b1, 32'h80000000, 32'h80000000);
    chk("R9 full wrap", acc, '0);

    // Alternating signs return to the start value (R10).
    cyc(1'b1, 1'b0, 32'h0, 32'h0);
    for (int i = 0; i < 20; i++) begin
      logic [N-1:0] x;
      logic [N-1:0] y;
      x = $urandom & 32'h7FFFFFFF;
      y = (i == 0) ? 32'h80000000 : $urandom;
      cyc(1'b0, 1'b1, x, y);
      cyc(1'b0, 1'b1, 32'(32'h0 - x), y);
      chk("R10 alternating pair", acc, '0);
    end

    // Asynchronous reset in the middle of a sum (R1).
    cyc(1'b1, 1'b1, 32'h00000005, 32'h00000007);
    chk("R4 load before reset", acc, 72'd35);
    vld   = 1'b0;
    clr   = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", acc, '0);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after second release", acc, '0);

    // Random mix against the behavioural sum (R2, R3, R4, R5).
    for (int i = 0; i < 10000; i++) begin
      logic [N-1:0] x;
      logic [N-1:0] y;
      x = (i % 50 == 0) ? 32'h80000000 : $urandom;
      y = (i % 70 == 3) ? 32'h80000000 : $urandom;
      cyc((i % 97) == 0, (i % 13) != 5, x, y);
      chk("R2 random accumulate", acc, model);
    end

    finish_run();
  end

endmodule